// File: doc/BRIEF.md
# Three-Wire Control Word Receiver

This block receives control settings for an audio converter over a three-wire serial link: a serial clock, a serial data line and a framing (latch) line. While the latch line is low, a data bit is taken on each rising edge of the serial clock. When the latch line rises, the collected word is checked. If exactly the expected number of bits arrived, the word is copied into the control register that feeds the converter.

All three serial lines are asynchronous to the system clock. Each one passes through a two-flop synchroniser, and every edge is found in the system clock domain. Two access styles work without any configuration. In the free-running style, the serial clock keeps toggling while the latch is high, and those edges are ignored. In the burst style, the serial clock rests low whenever the latch is high.

The register provides four controls: a 10-bit requested volume, a mute request for both channels, a de-emphasis enable and a soft power-down. The de-emphasis output is the OR of the register bit and a dedicated input pin. The datapath reset output is asserted for any of three causes: the system reset, the active-low hardware power-down pin, or the soft power-down bit. Only the hardware pin and the system reset return the control register to its defaults.

Top module: `serial_ctrl_latch`

## Requirements
- R1: After system reset, the volume output is all ones (1023), and mute, de-emphasis and soft power-down are all 0.
- R2: A word is received MSB first and is 16 bits long. Word bits 9..0 set the 10-bit volume request.
- R3: Word bit 11 drives the mute output, which mutes both channels when set.
- R4: The de-emphasis output is high when word bit 12 is stored as 1 or when the de-emphasis pin is high.
- R5: Word bit 13 drives the soft power-down output. The datapath reset output is high whenever that bit is set, the hardware power-down pin is low, or the system reset is active.
- R6: Word bits 15, 14 and 10 have no effect on any output.
- R7: A frame that carries any number of serial clock rising edges other than 16 (for example 15 or 17) is discarded, and all outputs keep their previous values.
- R8: Serial clock edges that occur while the latch line is high are ignored. Burst framing, with the clock held low while the latch is high, is also accepted.
- R9: While the hardware power-down pin is low, the control register is held at the R1 defaults.
- R10: The control outputs change only when a word is committed or when a reset occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| hw_pd_n | input | 1 | Hardware power-down/reset pin, active low, asynchronous |
| deemph_pin | input | 1 | De-emphasis request pin, asynchronous |
| cclk | input | 1 | Serial clock |
| cdata | input | 1 | Serial data |
| clatch | input | 1 | Serial framing/latch line |
| vol_req_o | output | 10 | Requested volume level |
| mute_o | output | 1 | Mute request for both channels |
| deemph_o | output | 1 | De-emphasis enable (register bit OR pin) |
| soft_pd_o | output | 1 | Stored soft power-down bit |
| dp_rst_o | output | 1 | Reset for the downstream datapath |

## Verification
The assertions check the following on every cycle:
- The reset state.
- That the datapath reset follows the soft power-down bit and the power-down pin.
- That the de-emphasis pin always reaches its output.
- That a commit happens only when the bit count is exactly 16.
- That the outputs stay unchanged when no commit or reset occurs.

Only the bench scenarios can show the following:
- That bits land in the right fields in MSB-first order.
- That the reserved bits have no effect.
- That short and long frames are rejected at the ports.
- That both the free-running and burst clock styles deliver identical results.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int WORD_W      = 16;
  localparam int VOL_W       = 10;
  localparam int MUTE_POS    = 11;
  localparam int DEEMPH_POS  = 12;
  localparam int SOFTPD_POS  = 13;
  localparam int SYNC_STAGES = 2;
  // index of each line inside the synchroniser vector
  localparam int S_CCLK   = 0;
  localparam int S_CDATA  = 1;
  localparam int S_CLATCH = 2;
  localparam int S_DEEMPH = 3;
  localparam int S_PDN    = 4;
  localparam int S_W      = 5;
  // idle levels: latch high, power-down pin released
  localparam logic [S_W-1:0] S_IDLE = 5'b10100;
endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/scl_shifter.sv
module scl_shifter #(
  parameter int W  = 16,
  localparam int CW = $clog2(W + 2)
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          sclk_s,
  input  logic          sdata_s,
  input  logic          latch_s,
  output logic          commit_o,
  output logic [W-1:0]  word_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] FULL = CW'(W);
  localparam logic [CW-1:0] OVER = CW'(W + 1);

  logic          sclk_d, latch_d;
  logic [W-1:0]  sh_q;
  logic [CW-1:0] cnt_q, cnt_base;
  logic          sclk_rise, latch_rise, latch_fall, take_bit;

  assign sclk_rise  = sclk_s & ~sclk_d;
  assign latch_rise = latch_s & ~latch_d;
  assign latch_fall = ~latch_s & latch_d;
  assign take_bit   = ~latch_s & sclk_rise;
  assign cnt_base   = latch_fall ? '0 : cnt_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      sclk_d   <= 1'b0;
      latch_d  <= 1'b1;
      sh_q     <= '0;
      cnt_q    <= '0;
      commit_o <= 1'b0;
      word_o   <= '0;
    end else begin
      sclk_d   <= sclk_s;
      latch_d  <= latch_s;
      commit_o <= 1'b0;
      if (take_bit) begin
        sh_q  <= {sh_q[W-2:0], sdata_s};
        cnt_q <= (cnt_base == OVER) ? OVER : cnt_base + 1'b1;
      end else begin
        cnt_q <= cnt_base;
      end
      if (latch_rise && cnt_q == FULL) begin
        commit_o <= 1'b1;
        word_o   <= sh_q;
      end
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/scl_regfile.sv
module scl_regfile
  import scl_pkg::*;
#(
  parameter int W    = WORD_W,
  parameter int VW   = VOL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          commit,
  input  logic [W-1:0]  word,
  input  logic          deemph_pin_s,
  output logic [VW-1:0] vol_o,
  output logic          mute_o,
  output logic          deemph_bit_o,
  output logic          deemph_o,
  output logic          softpd_o,
  output logic          dp_rst_o
);
  logic unused_rsvd;
  assign unused_rsvd = ^{word[W-1:SOFTPD_POS+1], word[MUTE_POS-1:VW]};

  always_ff @(posedge clk) begin
    if (clr) begin
      vol_o        <= '1;
      mute_o       <= 1'b0;
      deemph_bit_o <= 1'b0;
      softpd_o     <= 1'b0;
    end else if (commit) begin
      vol_o        <= word[VW-1:0];
      mute_o       <= word[MUTE_POS];
      deemph_bit_o <= word[DEEMPH_POS];
      softpd_o     <= word[SOFTPD_POS];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      deemph_o <= 1'b0;
      dp_rst_o <= 1'b1;
    end else begin
      deemph_o <= deemph_pin_s | (deemph_bit_o & ~clr);
      dp_rst_o <= clr | softpd_o;
    end
  end
endmodule

// File: rtl/serial_ctrl_latch.sv
module serial_ctrl_latch
  import scl_pkg::*;
#(
  parameter int WORD_BITS = WORD_W,
  parameter int VOL_BITS  = VOL_W,
  localparam int CNT_W    = $clog2(WORD_BITS + 2)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hw_pd_n,
  input  logic                deemph_pin,
  input  logic                cclk,
  input  logic                cdata,
  input  logic                clatch,
  output logic [VOL_BITS-1:0] vol_req_o,
  output logic                mute_o,
  output logic                deemph_o,
  output logic                soft_pd_o,
  output logic                dp_rst_o
);
  logic [S_W-1:0]       raw_v, syn_v;
  logic                 pd_n_s, deemph_pin_s, clr;
  logic                 commit_w;
  logic [WORD_BITS-1:0] word_w;
  logic [CNT_W-1:0]     cnt_w;
  logic                 deemph_bit_w;

  always_comb begin
    raw_v           = '0;
    raw_v[S_CCLK]   = cclk;
    raw_v[S_CDATA]  = cdata;
    raw_v[S_CLATCH] = clatch;
    raw_v[S_DEEMPH] = deemph_pin;
    raw_v[S_PDN]    = hw_pd_n;
  end

  scl_sync #(.W(S_W), .STAGES(SYNC_STAGES), .RST_VAL(S_IDLE)) u_sync (
    .clk (clk), .rst (rst), .d (raw_v), .q (syn_v)
  );

  assign pd_n_s       = syn_v[S_PDN];
  assign deemph_pin_s = syn_v[S_DEEMPH];
  assign clr          = rst | ~pd_n_s;

  scl_shifter #(.W(WORD_BITS)) u_shift (
    .clk      (clk),
    .clr      (clr),
    .sclk_s   (syn_v[S_CCLK]),
    .sdata_s  (syn_v[S_CDATA]),
    .latch_s  (syn_v[S_CLATCH]),
    .commit_o (commit_w),
    .word_o   (word_w),
    .cnt_o    (cnt_w)
  );

  scl_regfile #(.W(WORD_BITS), .VW(VOL_BITS)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .clr          (clr),
    .commit       (commit_w),
    .word         (word_w),
    .deemph_pin_s (deemph_pin_s),
    .vol_o        (vol_req_o),
    .mute_o       (mute_o),
    .deemph_bit_o (deemph_bit_w),
    .deemph_o     (deemph_o),
    .softpd_o     (soft_pd_o),
    .dp_rst_o     (dp_rst_o)
  );
endmodule

// File: rtl/scl_checker.sv
module scl_checker #(
  parameter int WB = 16,
  parameter int VB = 10,
  parameter int CB = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          pd_n_s,
  input logic          deemph_pin_s,
  input logic          commit,
  input logic [CB-1:0] cnt,
  input logic [VB-1:0] vol,
  input logic          mute,
  input logic          deemph,
  input logic          softpd,
  input logic          dp_rst
);
  assert_reset_defaults_R1: assert property (@(posedge clk)
    rst |=> (vol == '1 && !mute && !softpd && dp_rst));

  assert_pd_pin_defaults_R9: assert property (@(posedge clk) disable iff (rst)
    !pd_n_s |=> (vol == '1 && !mute && !softpd));

  assert_softpd_resets_dp_R5: assert property (@(posedge clk) disable iff (rst)
    (softpd || !pd_n_s) |=> dp_rst);

  assert_pin_deemph_R4: assert property (@(posedge clk) disable iff (rst)
    deemph_pin_s |=> deemph);

  assert_commit_exact_count_R7: assert property (@(posedge clk) disable iff (rst)
    commit |-> (cnt == CB'(WB)));

  assert_hold_without_commit_R10: assert property (@(posedge clk) disable iff (rst)
    (!commit && pd_n_s) |=> ($stable(vol) && $stable(mute) && $stable(softpd)));
endmodule

bind serial_ctrl_latch scl_checker #(.WB(WORD_BITS), .VB(VOL_BITS), .CB(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .pd_n_s       (pd_n_s),
  .deemph_pin_s (deemph_pin_s),
  .commit       (commit_w),
  .cnt          (cnt_w),
  .vol          (vol_req_o),
  .mute         (mute_o),
  .deemph       (deemph_o),
  .softpd       (soft_pd_o),
  .dp_rst       (dp_rst_o)
);

// File: tb/tb_serial_ctrl_latch.sv
module tb_serial_ctrl_latch;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hw_pd_n = 1'b1, deemph_pin = 1'b0;
  logic cclk = 1'b0, cdata = 1'b0, clatch = 1'b1;
  logic [9:0] vol_req_o;
  logic mute_o, deemph_o, soft_pd_o, dp_rst_o;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  serial_ctrl_latch dut (
    .clk (clk), .rst (rst), .hw_pd_n (hw_pd_n), .deemph_pin (deemph_pin),
    .cclk (cclk), .cdata (cdata), .clatch (clatch),
    .vol_req_o (vol_req_o), .mute_o (mute_o), .deemph_o (deemph_o),
    .soft_pd_o (soft_pd_o), .dp_rst_o (dp_rst_o)
  );

  // {frame bits[17:0], bit count[4:0], burst, vol[9:0], mute, deemph, softpd}
  localparam logic [36:0] VEC [0:7] = '{
    {18'h00155, 5'd16, 1'b0, 10'h155, 1'b0, 1'b0, 1'b0},
    {18'h00A2B, 5'd16, 1'b1, 10'h22B, 1'b1, 1'b0, 1'b0},
    {18'h0C7FF, 5'd16, 1'b0, 10'h3FF, 1'b0, 1'b0, 1'b0},
    {18'h0100F, 5'd16, 1'b1, 10'h00F, 1'b0, 1'b1, 1'b0},
    {18'h00001, 5'd15, 1'b0, 10'h00F, 1'b0, 1'b1, 1'b0},
    {18'h00002, 5'd17, 1'b1, 10'h00F, 1'b0, 1'b1, 1'b0},
    {18'h02080, 5'd16, 1'b0, 10'h080, 1'b0, 1'b0, 1'b1},
    {18'h00000, 5'd16, 1'b1, 10'h000, 1'b0, 1'b0, 1'b0}
  };

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [17:0] bits, input int n, input bit burst);
    clatch = 1'b0;
    wait_clks(4);
    for (int i = n - 1; i >= 0; i--) begin
      cdata = bits[i];
      cclk  = 1'b0;
      wait_clks(4);
      cclk  = 1'b1;
      wait_clks(4);
    end
    cclk = 1'b0;
    wait_clks(4);
    clatch = 1'b1;
    if (!burst) begin
      // free-running clock while latched: edges must be ignored (R8)
      for (int k = 0; k < 3; k++) begin
        cdata = 1'b1; cclk = 1'b1; wait_clks(4);
        cclk = 1'b0; wait_clks(4);
      end
    end
    wait_clks(10);
  endtask

  initial begin
    string tag [0:7];
    tag = '{"R2 R8", "R3 R8", "R6", "R4 R8", "R7 short", "R7 long", "R5", "R2 R10"};
    wait_clks(4);
    chk("R1 vol", vol_req_o, 10'h3FF);
    chk("R1 mute", mute_o, 0);
    chk("R1 softpd", soft_pd_o, 0);
    chk("R1 deemph", deemph_o, 0);
    rst = 1'b0;
    wait_clks(6);
    chk("R5 dp_rst idle", dp_rst_o, 0);

    for (int v = 0; v < 8; v++) begin
      send(VEC[v][36:19], int'(VEC[v][18:14]), VEC[v][13]);
      chk({tag[v], " vol"}, vol_req_o, VEC[v][12:3]);
      chk({tag[v], " mute"}, mute_o, VEC[v][2]);
      chk({tag[v], " deemph"}, deemph_o, VEC[v][1]);
      chk({tag[v], " softpd"}, soft_pd_o, VEC[v][0]);
      chk({tag[v], " dp_rst"}, dp_rst_o, VEC[v][0]);
    end

    // R4: pin alone enables de-emphasis while register bit is 0
    deemph_pin = 1'b1;
    wait_clks(6);
    chk("R4 pin", deemph_o, 1);
    deemph_pin = 1'b0;
    wait_clks(6);
    chk("R4 pin off", deemph_o, 0);

    // R9: hardware pin restores defaults; R5 dp reset follows it
    send(18'h01A5A, 16, 1'b0);
    chk("R2 preload", vol_req_o, 10'h25A);
    hw_pd_n = 1'b0;
    wait_clks(6);
    chk("R9 vol", vol_req_o, 10'h3FF);
    chk("R9 mute", mute_o, 0);
    chk("R9 deemph", deemph_o, 0);
    chk("R5 pin dp_rst", dp_rst_o, 1);
    hw_pd_n = 1'b1;
    wait_clks(6);
    chk("R5 pin release", dp_rst_o, 0);
    chk("R10 after pd", vol_req_o, 10'h3FF);

    // R1: system reset mid-run
    send(18'h02123, 16, 1'b1);
    chk("R5 set", soft_pd_o, 1);
    rst = 1'b1;
    wait_clks(3);
    chk("R1 rerun vol", vol_req_o, 10'h3FF);
    chk("R1 rerun softpd", soft_pd_o, 0);
    rst = 1'b0;
    wait_clks(6);
    chk("R5 after rst", dp_rst_o, 0);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule